// File: doc/BRIEF.md
# Prefetch and Conditional Issue Controller

This block is the instruction front end of a processor core that runs either 32-bit or 16-bit instructions. It owns the program counter and a two-slot prefetch queue. Every step fetches one new instruction word and hands the oldest queued instruction onward. The program counter therefore always runs two instructions ahead of the instruction being issued. Each fetch request is tagged sequential or non-sequential so that the memory side can choose its access timing.

In the 32-bit state, the controller tests the four-bit condition field of the oldest instruction against the N, Z, C and V flags. An instruction whose condition fails is retired as skipped, and the executor never sees it. An instruction that passes goes to the executor together with a dispatch index for its decode table. The executor answers in the same cycle. It either lets the front end advance, naming the access type of the next fetch, or reports a flush with a new target address. After a flush, and after reset, the controller refills both slots from the new address before it issues anything again.

Top module: `fe_issue_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no instruction is issued or skipped. The first fetch request goes to the reset vector (default 0) tagged non-sequential, and nothing is issued until two fetches have completed.
- R2: A refill, which follows reset or a flush, makes exactly two fetches. The first is tagged non-sequential (fetch_seq = 0) and the second sequential (fetch_seq = 1). Each one advances the PC by the instruction size (4 in the 32-bit state, 2 in the 16-bit state). The first fetch after a refill is tagged sequential.
- R3: fetch_addr is the PC with bits 1:0 cleared in the 32-bit state and only bit 0 cleared in the 16-bit state (half_mode = 1). In the 16-bit state the instruction is taken from fetch_rdata bits 15:0.
- R4: A fetch completes, and a step can happen, only in a cycle where fetch_valid and fetch_ready are both high. In any other cycle issue_valid and issue_skip stay low and no state changes. The queue is first in, first out: each step handles the older slot, and the newly fetched word becomes the younger slot.
- R5: During a step, issue_pc equals the PC minus twice the instruction size, which is the address the handled instruction was fetched from.
- R6: In the 32-bit state the condition is instruction bits 31:28, and flags is {N,Z,C,V} from bit 3 down to bit 0. The codes pass as follows:
  - 0 and 1: Z and not Z.
  - 2 and 3: C and not C.
  - 4 and 5: N and not N.
  - 6 and 7: V and not V.
  - 8: C and not Z.
  - 9: not C or Z.
  - 10 and 11: N==V and N!=V.
  - 12: not Z and N==V.
  - 13: Z or N!=V.
  - 14: always passes.
  - 15: never passes.
- R7: On a failed condition, issue_skip pulses and issue_valid stays low. The PC advances by 4, the next fetch is tagged non-sequential, and exec_flush, exec_seq and exec_target are ignored.
- R8: On an issued instruction with exec_flush low, the PC advances by the instruction size and the next fetch takes its tag from exec_seq.
- R9: On an issued instruction with exec_flush high, the PC does not advance. It is loaded with exec_target, the queue contents are dropped, and a refill starts.
- R10: In the 16-bit state no condition is tested: every step issues. issue_insn is the 16-bit instruction zero-extended to 32 bits.
- R11: issue_idx is {insn[27:20], insn[7:4]} in the 32-bit state and {2'b00, insn[15:6]} in the 16-bit state.
- R12: issue_valid and issue_skip are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | output | 1 | Fetch request present (high outside reset) |
| fetch_ready | input | 1 | Memory accepts the request and returns fetch_rdata this cycle |
| fetch_addr | output | ADDR_W | Aligned fetch address |
| fetch_seq | output | 1 | 1 = sequential access, 0 = non-sequential |
| fetch_rdata | input | 32 | Fetched instruction word (16-bit state: bits 15:0) |
| half_mode | input | 1 | 1 = 16-bit instruction state, 0 = 32-bit state |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| issue_valid | output | 1 | Oldest instruction is handed to the executor this cycle |
| issue_skip | output | 1 | Oldest instruction is retired without execution this cycle |
| issue_insn | output | 32 | Instruction being handled |
| issue_idx | output | 12 | Dispatch index for the executor |
| issue_pc | output | ADDR_W | Address of the handled instruction |
| exec_flush | input | 1 | Executor reply: pipeline flushed, redirect to exec_target |
| exec_seq | input | 1 | Executor reply: access type of the next fetch on advance |
| exec_target | input | ADDR_W | New PC on flush |

## Verification
A condition skip and an executor flush request can fall in the same step. So can a memory stall and a flush request. The bench holds exec_flush high across steps whose instruction fails its condition, and it also raises exec_flush in cycles where fetch_ready is low. A correct design must skip and fall through to PC+4 with a non-sequential tag, and it must not redirect until a step actually issues. Every condition code is also swept against all sixteen flag combinations. Both cases are judged by comparing each cycle's fetch address, fetch tag, issue, skip and index against a reference PC and queue phase tracked in the bench from the requirements.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [1:0] {
        PH_FILL0 = 2'd0,
        PH_FILL1 = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_ADV   = 2'd2,
        ST_FLUSH = 2'd3
    } step_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int INSN_W = 32;
    localparam int IDX_W  = 12;

    function automatic logic cc_eval(input logic [3:0] cc, input nzcv_t f);
        logic r;
        case (cc)
            4'd0:    r = f.z;
            4'd1:    r = !f.z;
            4'd2:    r = f.c;
            4'd3:    r = !f.c;
            4'd4:    r = f.n;
            4'd5:    r = !f.n;
            4'd6:    r = f.v;
            4'd7:    r = !f.v;
            4'd8:    r = f.c && !f.z;
            4'd9:    r = !f.c || f.z;
            4'd10:   r = (f.n == f.v);
            4'd11:   r = (f.n != f.v);
            4'd12:   r = !f.z && (f.n == f.v);
            4'd13:   r = f.z || (f.n != f.v);
            4'd14:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] disp_idx(input logic [INSN_W-1:0] w,
                                                  input logic half);
        return half ? {2'b00, w[15:6]} : {w[27:20], w[7:4]};
    endfunction

endpackage

// File: rtl/fe_cond_eval.sv
module fe_cond_eval
    import fe_pkg::*;
(
    input  logic [3:0] cc,
    input  nzcv_t      flg,
    input  logic       half,
    output logic       pass
);
    // 16-bit state issues unconditionally; 32-bit state tests the field
    assign pass = half ? 1'b1 : cc_eval(cc, flg);
endmodule

// File: rtl/fe_prefetch_buf.sv
module fe_prefetch_buf #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_first,
    input  logic         wr_second,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] oldest
);
    logic [W-1:0] slot0, slot1;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0 <= '0;
            slot1 <= '0;
        end else if (shift) begin
            slot0 <= slot1;
            slot1 <= din;
        end else begin
            if (wr_first)  slot0 <= din;
            if (wr_second) slot1 <= din;
        end
    end

    assign oldest = slot0;
endmodule

// File: rtl/fe_pc_ctrl.sv
module fe_pc_ctrl
    import fe_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              half,
    input  step_e             step,
    input  logic              exec_seq,
    input  logic [ADDR_W-1:0] target,
    output phase_e            phase,
    output logic [ADDR_W-1:0] pc,
    output logic              seq_tag
);
    localparam logic [ADDR_W-1:0] STEP32 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP16 = ADDR_W'(2);

    logic              nseq;
    logic [ADDR_W-1:0] isz;

    assign isz = half ? STEP16 : STEP32;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FILL0;
            pc    <= RESET_VEC;
            nseq  <= 1'b0;
        end else if (fire) begin
            case (phase)
                PH_FILL0: begin
                    pc    <= pc + isz;
                    phase <= PH_FILL1;
                end
                PH_FILL1: begin
                    pc    <= pc + isz;
                    phase <= PH_RUN;
                    nseq  <= 1'b1;
                end
                default: begin
                    case (step)
                        ST_SKIP: begin
                            pc   <= pc + STEP32;
                            nseq <= 1'b0;
                        end
                        ST_ADV: begin
                            pc   <= pc + isz;
                            nseq <= exec_seq;
                        end
                        ST_FLUSH: begin
                            pc    <= target;
                            phase <= PH_FILL0;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_FILL0: seq_tag = 1'b0;
            PH_FILL1: seq_tag = 1'b1;
            default:  seq_tag = nseq;
        endcase
    end
endmodule

// File: rtl/fe_issue_ctrl.sv
module fe_issue_ctrl
    import fe_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_seq,
    input  logic [31:0]       fetch_rdata,
    input  logic              half_mode,
    input  logic [3:0]        flags,
    output logic              issue_valid,
    output logic              issue_skip,
    output logic [31:0]       issue_insn,
    output logic [11:0]       issue_idx,
    output logic [ADDR_W-1:0] issue_pc,
    input  logic              exec_flush,
    input  logic              exec_seq,
    input  logic [ADDR_W-1:0] exec_target
);
    localparam logic [ADDR_W-1:0] LAG32 = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] LAG16 = ADDR_W'(4);

    phase_e            phase;
    step_e             step;
    logic [ADDR_W-1:0] pc;
    logic [INSN_W-1:0] oldest;
    logic              fire, run_fire, pass;

    assign fetch_valid = !rst;
    assign fire        = fetch_valid && fetch_ready;
    assign run_fire    = fire && (phase == PH_RUN);

    fe_pc_ctrl #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
        .clk(clk), .rst(rst), .fire(fire), .half(half_mode), .step(step),
        .exec_seq(exec_seq), .target(exec_target),
        .phase(phase), .pc(pc), .seq_tag(fetch_seq)
    );

    fe_prefetch_buf #(.W(INSN_W)) u_buf (
        .clk(clk), .rst(rst),
        .wr_first(fire && (phase == PH_FILL0)),
        .wr_second(fire && (phase == PH_FILL1)),
        .shift(run_fire), .din(fetch_rdata), .oldest(oldest)
    );

    fe_cond_eval u_cond (
        .cc(oldest[31:28]), .flg(nzcv_t'(flags)), .half(half_mode), .pass(pass)
    );

    always_comb begin
        if (!run_fire)       step = ST_NONE;
        else if (!pass)      step = ST_SKIP;
        else if (exec_flush) step = ST_FLUSH;
        else                 step = ST_ADV;
    end

    assign fetch_addr  = {pc[ADDR_W-1:2], half_mode & pc[1], 1'b0};
    assign issue_valid = run_fire && pass;
    assign issue_skip  = run_fire && !pass;
    assign issue_insn  = half_mode ? {16'h0000, oldest[15:0]} : oldest;
    assign issue_idx   = disp_idx(oldest, half_mode);
    assign issue_pc    = pc - (half_mode ? LAG16 : LAG32);

    // R12
    issue_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({issue_valid, issue_skip}));

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |-> (!issue_valid && !issue_skip));

    // R7
    skip_nonseq_chk: assert property (@(posedge clk) disable iff (rst)
        issue_skip |=> !fetch_seq);

    // R7
    skip_step4_chk: assert property (@(posedge clk) disable iff (rst)
        issue_skip |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(4)));

    // R8
    adv_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !exec_flush) |=> (fetch_seq == $past(exec_seq)));

    // R9
    flush_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && exec_flush) |=>
            (!fetch_seq && !issue_valid && !issue_skip &&
             fetch_addr[ADDR_W-1:2] == $past(exec_target[ADDR_W-1:2])));

    // R10
    half_noskip_chk: assert property (@(posedge clk) disable iff (rst)
        half_mode |-> !issue_skip);
endmodule

// File: tb/test_fe_issue_ctrl.sv
module test_fe_issue_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid, fetch_ready = 1'b0, fetch_seq;
    logic [31:0] fetch_addr, fetch_rdata;
    logic        half_mode = 1'b0;
    logic [3:0]  flags = 4'h0;
    logic        issue_valid, issue_skip;
    logic [31:0] issue_insn, issue_pc;
    logic [11:0] issue_idx;
    logic        exec_flush = 1'b0, exec_seq = 1'b1;
    logic [31:0] exec_target = 32'h0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state derived from the requirements
    int          m_ph = 0;
    logic [31:0] m_pc = 32'h0;
    logic        m_seq = 1'b0;
    logic        m_half = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #4 clk = ~clk;

    fe_issue_ctrl i_fe_issue_ctrl (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_seq(fetch_seq), .fetch_rdata(fetch_rdata),
        .half_mode(half_mode), .flags(flags), .issue_valid(issue_valid),
        .issue_skip(issue_skip), .issue_insn(issue_insn), .issue_idx(issue_idx),
        .issue_pc(issue_pc), .exec_flush(exec_flush), .exec_seq(exec_seq),
        .exec_target(exec_target)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[5:2], 4'hA, a[23:0]};
    endfunction

    always_comb fetch_rdata = memf(fetch_addr);

    function automatic logic ref_cc(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            0: return z;           1: return !z;
            2: return c;           3: return !c;
            4: return n;           5: return !n;
            6: return v;           7: return !v;
            8: return c & !z;      9: return !c | z;
            10: return n == v;     11: return n != v;
            12: return !z & (n == v);
            13: return z | (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic rdy, input logic fl, input logic es,
                       input logic [31:0] tgt, input logic [3:0] f);
        logic [31:0] sz, mask, ea, w, ei;
        logic        es_exp, pass;
        @(negedge clk);
        fetch_ready = rdy; exec_flush = fl; exec_seq = es; exec_target = tgt; flags = f;
        #1;
        sz   = m_half ? 32'd2 : 32'd4;
        mask = m_half ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
        ea   = m_pc & mask;
        chk(fetch_addr == ea, "R3 fetch address", fetch_addr, ea);
        es_exp = (m_ph == 0) ? 1'b0 : (m_ph == 1) ? 1'b1 : m_seq;
        chk(fetch_seq == es_exp, "R2/R8 fetch tag", {31'd0, fetch_seq}, {31'd0, es_exp});
        if (m_ph == 2 && rdy) begin
            w    = memf((m_pc - 2 * sz) & mask);
            pass = m_half ? 1'b1 : ref_cc(w[31:28], f);
            chk(issue_valid == pass, m_half ? "R10 issue" : "R6 cond issue",
                {31'd0, issue_valid}, {31'd0, pass});
            chk(issue_skip == !pass, "R7 skip", {31'd0, issue_skip}, {31'd0, !pass});
            chk(!(issue_valid && issue_skip), "R12 exclusive",
                {30'd0, issue_valid, issue_skip}, 32'd0);
            chk(issue_pc == m_pc - 2 * sz, "R5 issue pc", issue_pc, m_pc - 2 * sz);
            ei = m_half ? {16'h0, w[15:0]} : w;
            chk(issue_insn == ei, "R4 fifo order", issue_insn, ei);
            ei = m_half ? {22'd0, w[15:6]} : {20'd0, w[27:20], w[7:4]};
            chk({20'd0, issue_idx} == ei, "R11 index", {20'd0, issue_idx}, ei);
            if (!pass) begin
                m_pc = m_pc + 4; m_seq = 1'b0;
            end else if (fl) begin
                m_pc = tgt; m_ph = 0;
            end else begin
                m_pc = m_pc + sz; m_seq = es;
            end
        end else begin
            chk(!issue_valid && !issue_skip, "R4 no step",
                {30'd0, issue_valid, issue_skip}, 32'd0);
            if (rdy) begin
                m_pc = m_pc + sz;
                if (m_ph == 1) m_seq = 1'b1;
                m_ph = m_ph + 1;
            end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!issue_valid && !issue_skip, "R1 quiet in reset",
            {30'd0, issue_valid, issue_skip}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch_addr == 32'h0 && !fetch_seq && !issue_valid, "R1 reset vector",
            fetch_addr, 32'h0);
        // R1/R2: reload with a stall inside it
        cyc(1'b1, 1'b0, 1'b1, 32'h0, 4'h0);
        cyc(1'b0, 1'b1, 1'b1, 32'h40, 4'h0);
        cyc(1'b1, 1'b0, 1'b1, 32'h0, 4'h0);
        // R6: every condition code against every flag value
        for (int f = 0; f < 16; f++)
            for (int k = 0; k < 16; k++)
                cyc(1'b1, 1'b0, 1'b1, 32'h0, f[3:0]);
        // R4/R8: stalls, alternating tags, flush requests in stalled cycles
        for (int k = 0; k < 48; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0], !lfsr[0], lfsr[1], 32'h0000_0800, lfsr[7:4]);
        end
        // R9/R7: flush held; skipped steps must not redirect
        while (m_ph == 2) cyc(1'b1, 1'b1, 1'b0, 32'h0000_1000, 4'h2);
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0, k[0], 32'h0, 4'h6);
        // R10: switch to 16-bit state through a flush
        while (m_ph == 2) cyc(1'b1, 1'b1, 1'b1, 32'h0000_2002, 4'hF);
        half_mode = 1'b1; m_half = 1'b1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[2] | lfsr[3], 1'b0, lfsr[1], 32'h0, 4'h0);
        end
        // back to 32-bit state
        while (m_ph == 2) cyc(1'b1, 1'b1, 1'b1, 32'h0000_3000, 4'h0);
        half_mode = 1'b0; m_half = 1'b0;
        for (int k = 0; k < 24; k++) cyc(1'b1, 1'b0, 1'b1, 32'h0, 4'h4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule